// File: doc/BRIEF.md
# Double-Buffered Real-Time-Clock Register Window

This block places a real-time clock behind a bytewide, memory-mapped bus. The bus has a 13-bit address, 8-bit write and read data, and active-low select, output-enable and write-enable strobes. All of them are sampled on the system clock. The top eight byte addresses form the clock window. Every lower address passes straight through to a plain RAM port. The calendar arithmetic sits in a separate counter block. That block presents its current time on a 56-bit bus and flags each change with a one-cycle tick. It also accepts a one-cycle load strobe with a new time value.

Inside the window, software sees a visible copy of the time bytes. A control byte carries two halt bits and a BCD century value. The read-freeze bit holds the visible copy still while the counter keeps running. The write-freeze bit redirects time writes into holding registers. Clearing the write-freeze bit hands the held time to the counter. Each halt bit has its own rule for whether a control write changes the century. The day byte reports a battery status flag in its top bit.

Top module: `rtc_bw_top`

## Requirements
- R1: Addresses 0x1FF8 to 0x1FFF form the clock window, with byte index = address bits 2:0. Index 7 is year, 6 month, 5 date, 4 day, 3 hour, 2 minutes, 1 seconds and 0 control. In `cnt_now` and `cnt_set`, index k occupies bits 8k-1:8k-8. Any lower address asserts `ram_sel` while selected, asserts `ram_we` on a write, and its read data comes from `ram_rdata`. `ram_sel` and `ram_we` stay low inside the window.
- R2: A read is `bus_sel_n`=0, `bus_oe_n`=0 and `bus_we_n`=1. During a read, `bus_drive`=1 and `bus_rdata` carries the addressed byte. Otherwise `bus_drive`=0 and `bus_rdata`=0. A write is `bus_sel_n`=0 and `bus_we_n`=0, whatever `bus_oe_n` is.
- R3: The control byte reads as {write-freeze bit 7, read-freeze bit 6, century bits 5:0}. After reset, both halt bits are 0, the century is 0x20, and every time byte and holding byte is 0.
- R4: A control write that sets the write-freeze bit from 0 copies the visible time bytes into the holding bytes. While the bit is 1, time-byte writes update both the holding byte and the visible byte. While it is 0, time-byte writes are ignored.
- R5: A control write that clears a set write-freeze bit makes the visible bytes take the held values. `cnt_load` then pulses high for exactly the next cycle, with `cnt_set` equal to the held time.
- R6: While the read-freeze bit is 1 and the write-freeze bit is 0, ticks leave the visible time bytes unchanged.
- R7: A control write with bit 7 or bit 6 at 1 leaves the century unchanged. A write of both bits 0 loads bits 5:0 into the century if the write-freeze bit was 1, or if neither halt bit was set. It leaves the century unchanged if only the read-freeze bit was set.
- R8: After the read-freeze bit is cleared, the first tick refreshes every visible time byte from `cnt_now`.
- R9: With both halt bits 0, each `cnt_tick` loads all seven visible time bytes from `cnt_now` at the same clock edge.
- R10: Day bit 7 reads as the inverse of `batt_low`. Bit 7 of written day data and of `cnt_now` day data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_drive | output | 1 | High when the read data should be driven onto the pins |
| ram_sel | output | 1 | RAM select for addresses below the window |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 13 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| cnt_tick | input | 1 | Counter updated this cycle |
| cnt_now | input | 56 | Running counter time, seven bytes |
| cnt_load | output | 1 | One-cycle strobe to load the counter |
| cnt_set | output | 56 | Time to load into the counter |
| batt_low | input | 1 | Battery low indication |

## Verification
The assertions check several properties on every cycle. The visible time stays frozen while only the read-freeze bit is set. The century holds across any control write that sets a halt bit. A load strobe follows each clear of the write-freeze bit and carries the held time. The battery flag appears on day reads, and RAM writes never hit the window. Some behaviours only the bench scenarios can show: the ignored time writes while unfrozen, the century load after a write-freeze release, the refresh on the first tick after a read-freeze release, and the byte order of the window. For these, the bench compares a behavioural model against the block's outputs on every clock.

// File: rtl/rtc_bw_pkg.sv
package rtc_bw_pkg;
   localparam int unsigned NREG     = 8;
   localparam int unsigned CTRL_IDX = 0;
   localparam int unsigned DAY_IDX  = 4;
   localparam int unsigned IDX_W    = $clog2(NREG);
   typedef logic [7:0] byte_t;
endpackage

// File: rtl/rtc_bw_decode.sv
module rtc_bw_decode #(
   parameter int unsigned ADDR_W = 13
) (
   input  logic              sel_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              rd_go,
   output logic              wr_go,
   output logic              in_win,
   output logic [2:0]        idx
);
   assign rd_go  = !sel_n && !oe_n && we_n;
   assign wr_go  = !sel_n && !we_n;
   assign in_win = &addr[ADDR_W-1:3];
   assign idx    = addr[2:0];
endmodule

// File: rtl/rtc_bw_bank.sv
module rtc_bw_bank
   import rtc_bw_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter logic [5:0]  CENT_RST = 6'h20,
   localparam int unsigned TIME_W  = (NREG - 1) * DATA_W,
   localparam int unsigned VIS_W   = NREG * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic              in_win,
   input  logic [2:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tick,
   input  logic [TIME_W-1:0] cnt_now,
   output logic [VIS_W-1:0]  vis_flat,
   output logic [TIME_W-1:0] hold_flat,
   output logic              load
);
   logic       w_q, r_q, load_q;
   logic [5:0] cent_q;
   logic       ctrl_wr, tm_wr, w_set, w_clear, run, cent_ld;

   assign ctrl_wr = wr_go && in_win && (idx == 3'(CTRL_IDX));
   assign tm_wr   = wr_go && in_win && (idx != 3'(CTRL_IDX)) && w_q;
   assign w_set   = ctrl_wr && !w_q && wdata[7];
   assign w_clear = ctrl_wr && w_q && !wdata[7];
   assign run     = !w_q && !r_q;
   assign cent_ld = ctrl_wr && !wdata[7] && !wdata[6] && (w_q || !r_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_q    <= 1'b0;
         r_q    <= 1'b0;
         cent_q <= CENT_RST;
         load_q <= 1'b0;
      end else begin
         load_q <= w_clear;
         if (ctrl_wr) begin
            w_q <= wdata[7];
            r_q <= wdata[6];
         end
         if (cent_ld) cent_q <= wdata[5:0];
      end
   end

   assign vis_flat[DATA_W-1:0] = {w_q, r_q, cent_q};
   assign load = load_q;

   for (genvar k = 1; k < NREG; k++) begin : g_reg
      localparam logic [DATA_W-1:0] MASK =
         (k == DAY_IDX) ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
      logic [DATA_W-1:0] vis_q, hold_q;
      logic              hit;
      assign hit = tm_wr && (idx == 3'(k));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vis_q  <= '0;
            hold_q <= '0;
         end else begin
            if (w_set)    hold_q <= vis_q;
            else if (hit) hold_q <= wdata & MASK;
            if (w_clear)          vis_q <= hold_q;
            else if (hit)         vis_q <= wdata & MASK;
            else if (run && tick) vis_q <= cnt_now[k*DATA_W-1 -: DATA_W] & MASK;
         end
      end
      assign vis_flat[(k+1)*DATA_W-1 -: DATA_W] = vis_q;
      assign hold_flat[k*DATA_W-1 -: DATA_W]    = hold_q;
   end
endmodule

// File: rtl/rtc_bw_rdmux.sv
module rtc_bw_rdmux
   import rtc_bw_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned VIS_W = NREG * DATA_W
) (
   input  logic              rd_go,
   input  logic              in_win,
   input  logic [2:0]        idx,
   input  logic [VIS_W-1:0]  vis_flat,
   input  logic              batt_low,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic              drive
);
   logic [DATA_W-1:0] win_b;
   always_comb begin
      win_b = vis_flat[{idx, 3'b000} +: DATA_W];
      if (idx == 3'(DAY_IDX)) win_b[DATA_W-1] = !batt_low;
      if (!rd_go)      rdata = '0;
      else if (in_win) rdata = win_b;
      else             rdata = ram_rdata;
   end
   assign drive = rd_go;
endmodule

// File: rtl/rtc_bw_top.sv
module rtc_bw_top
   import rtc_bw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 13,
   parameter int unsigned DATA_W   = 8,
   parameter logic [5:0]  CENT_RST = 6'h20,
   localparam int unsigned TIME_W  = (NREG - 1) * DATA_W,
   localparam int unsigned VIS_W   = NREG * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_n,
   input  logic              bus_oe_n,
   input  logic              bus_we_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_drive,
   output logic              ram_sel,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic              cnt_tick,
   input  logic [TIME_W-1:0] cnt_now,
   output logic              cnt_load,
   output logic [TIME_W-1:0] cnt_set,
   input  logic              batt_low
);
   if (ADDR_W < 4) begin : g_bad_addr
      $error("rtc_bw_top: ADDR_W must leave room for the window");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("rtc_bw_top: control byte layout needs DATA_W of 8");
   end

   logic             rd_go, wr_go, in_win;
   logic [2:0]       idx;
   logic [VIS_W-1:0] vis_flat;

   rtc_bw_decode #(.ADDR_W(ADDR_W)) u_dec (
      .sel_n(bus_sel_n), .oe_n(bus_oe_n), .we_n(bus_we_n), .addr(bus_addr),
      .rd_go(rd_go), .wr_go(wr_go), .in_win(in_win), .idx(idx)
   );

   rtc_bw_bank #(.DATA_W(DATA_W), .CENT_RST(CENT_RST)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .in_win(in_win), .idx(idx),
      .wdata(bus_wdata), .tick(cnt_tick), .cnt_now(cnt_now),
      .vis_flat(vis_flat), .hold_flat(cnt_set), .load(cnt_load)
   );

   rtc_bw_rdmux #(.DATA_W(DATA_W)) u_rd (
      .rd_go(rd_go), .in_win(in_win), .idx(idx), .vis_flat(vis_flat),
      .batt_low(batt_low), .ram_rdata(ram_rdata),
      .rdata(bus_rdata), .drive(bus_drive)
   );

   assign ram_sel   = !bus_sel_n && !in_win;
   assign ram_we    = wr_go && !in_win;
   assign ram_addr  = bus_addr;
   assign ram_wdata = bus_wdata;
endmodule

// File: rtl/rtc_bw_chk.sv
module rtc_bw_chk #(
   parameter int unsigned ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel_n,
   input logic              bus_we_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              bus_drive,
   input logic              ram_we,
   input logic              cnt_load,
   input logic [55:0]       cnt_set,
   input logic              batt_low,
   input logic [63:0]       vis_flat
);
   logic win_wr, ctl_wr, win_addr;
   assign win_addr = &bus_addr[ADDR_W-1:3];
   assign win_wr   = !bus_sel_n && !bus_we_n && win_addr;
   assign ctl_wr   = win_wr && (bus_addr[2:0] == 3'd0);

   // R6
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vis_flat[6] && !vis_flat[7] && !win_wr) |=> $stable(vis_flat[63:8]));
   // R7
   century_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && (bus_wdata[7] || bus_wdata[6])) |=> $stable(vis_flat[5:0]));
   // R5
   load_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && vis_flat[7] && !bus_wdata[7]) |=> cnt_load);
   // R5
   load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |-> ($past(vis_flat[7]) && !vis_flat[7] && cnt_set == vis_flat[63:8]));
   // R10
   batt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_drive && win_addr && bus_addr[2:0] == 3'd4) |-> (bus_rdata[7] == !batt_low));
   // R1
   ram_we_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> !win_addr);
endmodule

bind rtc_bw_top rtc_bw_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_we_n(bus_we_n),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .bus_drive(bus_drive), .ram_we(ram_we), .cnt_load(cnt_load),
   .cnt_set(cnt_set), .batt_low(batt_low), .vis_flat(vis_flat)
);

// File: tb/rtc_bw_top_tb.sv
`timescale 1ns/1ps
module rtc_bw_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1;
   logic [12:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata, ram_wdata, ram_rdata;
   logic        bus_drive, ram_sel, ram_we, cnt_load;
   logic [12:0] ram_addr;
   logic        cnt_tick = 1'b0, batt_low = 1'b0;
   logic [55:0] cnt_now = '0, cnt_set;

   int checks = 0, fails = 0;
   string cur_req = "R3";

   always #2.5 clk = ~clk;
   assign ram_rdata = ram_addr[7:0] ^ 8'hA5;

   rtc_bw_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_oe_n(bus_oe_n),
      .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_drive(bus_drive), .ram_sel(ram_sel),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .cnt_tick(cnt_tick), .cnt_now(cnt_now),
      .cnt_load(cnt_load), .cnt_set(cnt_set), .batt_low(batt_low)
   );

   // behavioural reference model
   logic [7:0] m_vis [1:7];
   logic [7:0] m_hold[1:7];
   logic       m_w, m_r, m_load;
   logic [5:0] m_cent;

   always @(posedge clk) begin
      logic [7:0] ov[1:7];
      logic ow, orr, wr, win;
      int ix;
      if (!rst_n) begin
         m_w = 0; m_r = 0; m_cent = 6'h20; m_load = 0;
         for (int k = 1; k < 8; k++) begin m_vis[k] = 0; m_hold[k] = 0; end
      end else begin
         for (int k = 1; k < 8; k++) ov[k] = m_vis[k];
         ow = m_w; orr = m_r; m_load = 0;
         wr  = !bus_sel_n && !bus_we_n;
         win = bus_addr >= 13'h1FF8;
         ix  = int'(bus_addr) - 'h1FF8;
         if (wr && win && ix == 0) begin
            if (!bus_wdata[7] && !bus_wdata[6] && (ow || !orr)) m_cent = bus_wdata[5:0];
            if (ow && !bus_wdata[7]) begin
               for (int k = 1; k < 8; k++) m_vis[k] = m_hold[k];
               m_load = 1;
            end
            if (!ow && bus_wdata[7])
               for (int k = 1; k < 8; k++) m_hold[k] = ov[k];
            m_w = bus_wdata[7]; m_r = bus_wdata[6];
         end else if (wr && win && ow) begin
            m_hold[ix] = (ix == 4) ? (bus_wdata & 8'h7F) : bus_wdata;
            m_vis[ix]  = m_hold[ix];
         end
         if (!ow && !orr && cnt_tick)
            for (int k = 1; k < 8; k++)
               m_vis[k] = cnt_now[8*k-1 -: 8] & ((k == 4) ? 8'h7F : 8'hFF);
      end
   end

   // per-cycle comparison
   always @(posedge clk) begin
      logic [7:0] e_rd; logic e_drv, e_sel, e_we; logic [55:0] e_set; int ix;
      #1;
      if (rst_n) begin
         ix    = int'(bus_addr) - 'h1FF8;
         e_drv = !bus_sel_n && !bus_oe_n && bus_we_n;
         e_sel = !bus_sel_n && bus_addr < 13'h1FF8;
         e_we  = !bus_sel_n && !bus_we_n && bus_addr < 13'h1FF8;
         for (int k = 1; k < 8; k++) e_set[8*k-1 -: 8] = m_hold[k];
         if (!e_drv) e_rd = 0;
         else if (bus_addr < 13'h1FF8) e_rd = bus_addr[7:0] ^ 8'hA5;
         else if (ix == 0) e_rd = {m_w, m_r, m_cent};
         else if (ix == 4) e_rd = {!batt_low, m_vis[4][6:0]};
         else e_rd = m_vis[ix];
         checks++;
         if (bus_rdata !== e_rd || bus_drive !== e_drv || ram_sel !== e_sel ||
             ram_we !== e_we || cnt_load !== m_load || cnt_set !== e_set) begin
            fails++;
            $display("FAIL %s at %h: rdata %h/%h drive %b/%b sel %b/%b we %b/%b load %b/%b set %h/%h",
               cur_req, bus_addr, bus_rdata, e_rd, bus_drive, e_drv, ram_sel, e_sel,
               ram_we, e_we, cnt_load, m_load, cnt_set, e_set);
         end
      end
   end

   task automatic idle();
      bus_sel_n = 1; bus_oe_n = 1; bus_we_n = 1;
   endtask
   task automatic wr(input logic [12:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_sel_n = 0; bus_we_n = 0;
      @(negedge clk); idle();
   endtask
   task automatic rd(input logic [12:0] a);
      bus_addr = a; bus_sel_n = 0; bus_oe_n = 0;
      @(negedge clk); idle();
   endtask
   task automatic rd_exp(input logic [12:0] a, input logic [7:0] exp, input string tag);
      bus_addr = a; bus_sel_n = 0; bus_oe_n = 0;
      @(posedge clk); #1;
      checks++;
      if (bus_rdata !== exp) begin
         fails++;
         $display("FAIL %s directed read %h: got %h exp %h", tag, a, bus_rdata, exp);
      end
      @(negedge clk); idle();
   endtask
   task automatic tick(input logic [55:0] v);
      cnt_now = v; cnt_tick = 1;
      @(negedge clk); cnt_tick = 0;
   endtask
   task automatic rd_all();
      for (int a = 'h1FF8; a <= 'h1FFF; a++) rd(13'(a));
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      cur_req = "R3";
      rd_exp(13'h1FF8, 8'h20, "R3");
      rd_exp(13'h1FFF, 8'h00, "R3");
      rd_exp(13'h1FFC, 8'h80, "R10");
      cur_req = "R2";
      bus_oe_n = 0; bus_addr = 13'h1FF9; @(negedge clk);
      bus_addr = 13'h0040; bus_sel_n = 0; bus_we_n = 0; bus_oe_n = 0; @(negedge clk); idle();
      cur_req = "R1";
      wr(13'h0123, 8'h3C); rd_exp(13'h0123, 8'h23 ^ 8'hA5, "R1");
      rd(13'h1FF7); rd(13'h0000);
      cur_req = "R9";
      tick(56'h25_06_15_03_12_34_56); rd_all();
      rd_exp(13'h1FFF, 8'h25, "R9"); rd_exp(13'h1FF9, 8'h56, "R9");
      cur_req = "R4";
      wr(13'h1FFF, 8'h99); rd_exp(13'h1FFF, 8'h25, "R4");
      cur_req = "R6";
      wr(13'h1FF8, 8'h40); rd_exp(13'h1FF8, 8'h60, "R7");
      tick(56'h25_06_15_03_12_35_07); rd_all();
      rd_exp(13'h1FF9, 8'h56, "R6");
      cur_req = "R7";
      wr(13'h1FF8, 8'h00); rd_exp(13'h1FF8, 8'h20, "R7");
      cur_req = "R8";
      rd_exp(13'h1FF9, 8'h56, "R8");
      tick(56'h25_06_15_03_12_35_08); rd_all();
      rd_exp(13'h1FF9, 8'h08, "R8");
      cur_req = "R4";
      wr(13'h1FF8, 8'h80); tick(56'h25_06_15_03_12_35_09); rd_all();
      rd_exp(13'h1FF9, 8'h08, "R4");
      wr(13'h1FFF, 8'h31); wr(13'h1FFE, 8'h12); wr(13'h1FF9, 8'h45);
      cur_req = "R10";
      wr(13'h1FFC, 8'hC5); rd_exp(13'h1FFC, 8'hC5, "R10");
      rd_exp(13'h1FFF, 8'h31, "R4");
      cur_req = "R5";
      wr(13'h1FF8, 8'h19); rd_all();
      rd_exp(13'h1FF8, 8'h19, "R7"); rd_exp(13'h1FFF, 8'h31, "R5");
      cur_req = "R7";
      wr(13'h1FF8, 8'hC7); rd_exp(13'h1FF8, 8'hD9, "R7");
      wr(13'h1FF8, 8'h00); rd_exp(13'h1FF8, 8'h00, "R7");
      wr(13'h1FF8, 8'h0A); rd_exp(13'h1FF8, 8'h0A, "R7");
      cur_req = "R10";
      batt_low = 1; tick(56'h99_12_31_87_23_59_59); rd_all();
      rd_exp(13'h1FFC, 8'h07, "R10");
      batt_low = 0; rd_exp(13'h1FFC, 8'h87, "R10");
      cur_req = "R9";
      tick(56'h00_01_01_01_00_00_00); rd_all();
      repeat (4) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule